// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general-purpose registers and the saved-status registers of a 32-bit processor core that runs in several privilege modes. In every mode, software addresses sixteen architectural registers by a 4-bit number. Register 13 serves as the stack pointer, register 14 as the link register, and register 15 as the program counter. Some of these numbers lead to a different physical register depending on the current mode.

The fast-interrupt mode has its own copies of registers 8 to 14. Four other exception modes each have their own copies of registers 13 and 14. These are the interrupt, supervisor, abort and undefined modes. Everything else is shared with user mode. System mode uses the user set unchanged. In total the block stores 30 physical registers and five saved-status words. There is one saved-status word for each exception mode.

The block has two read ports, which are combinational, and one write port, which is clocked. All three decode the same 5-bit mode input. Register 15 is not stored in the block. A read of it returns the external program counter. A write to it is reported on a strobe so that the fetch logic can take it. Both read ports and the saved-status read return the old value for the whole cycle in which a write to the same register happens.

Top module: `banked_regfile`

## Requirements
- R1: After a synchronous active-low reset, every one of registers 0 to 14 reads zero in every mode, and the saved-status read returns zero.
- R2: Registers 0 to 7 are a single physical set, shared by all modes. A write in any mode is seen in every other mode.
- R3: Registers 8 to 12 are shared by all modes except fast-interrupt mode (mode code 5'b10001), which has its own private copies of them.
- R4: Registers 13 and 14 have private copies in each of these modes: fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011). User mode (10000) and system mode (11111) share a single copy.
- R5: Any mode code other than the seven listed in R4 behaves exactly as user mode, for both register and saved-status access.
- R6: A read of register 15 on either read port returns `pc_in` in the same cycle.
- R7: A write with index 15 raises `pc_write` in that cycle and changes no stored register. `pc_write` is low in every other case.
- R8: A write is visible on the read ports from the next cycle on. A read of the same physical register in the write cycle returns the old value.
- R9: Each of the five exception modes has its own saved-status register. It is read and written through `sr_rd_data` and `sr_wr_en`/`sr_wr_data` while that mode is current, and it holds its value otherwise.
- R10: In user or system mode, `sr_rd_data` reads zero and a saved-status write is discarded.
- R11: The two read ports are independent. Each returns the register picked by its own index under the current mode, even when both ports read the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 5 | Current processor mode code |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | DATA_W | Read data, port A |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | DATA_W | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Architectural index of the write |
| wr_data | input | DATA_W | Write data |
| pc_in | input | DATA_W | External program counter, returned for index 15 |
| pc_write | output | 1 | Strobe: the current write targets index 15 |
| sr_wr_en | input | 1 | Saved-status write enable for the current mode |
| sr_wr_data | input | DATA_W | Saved-status write data |
| sr_rd_data | output | DATA_W | Saved-status value of the current mode |

## Verification
The bench targets the points where the mapping from index to physical register changes:
- Registers 7 against 8, and 12 against 13, when the bench moves into and out of fast-interrupt mode. A design with an off-by-one boundary there would leak a fast-interrupt value into user mode.
- System mode and undefined mode codes. A design that gave them a bank of their own would lose data that was written in user mode.
- Writes to register 15. A design that stored them would corrupt the physical register that shares that slot.
- Reads in the same cycle as a write to the same register. A design with an unintended bypass would show the new value one cycle early.
- Saved-status accesses in user and system mode. A design that lets them through would return stale words or overwrite another mode's copy.

// File: rtl/banked_rf_pkg.sv
// Package: shared mode classes, mode codes and physical layout constants
// for the banked register file. Assumes the 5-bit mode codes listed below.
package banked_rf_pkg;

    typedef enum logic [2:0] {
        CL_USR = 3'd0,
        CL_FIQ = 3'd1,
        CL_IRQ = 3'd2,
        CL_SVC = 3'd3,
        CL_ABT = 3'd4,
        CL_UND = 3'd5
    } mode_cls_e;

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    localparam int IDX_W     = 4;
    localparam int PC_IDX    = 15;
    localparam int USR_COUNT = 15;              // r0..r14 of the user set
    localparam int FIQ_FIRST = 8;               // first fast-interrupt private index
    localparam int FIQ_COUNT = 15 - FIQ_FIRST;  // r8..r14
    localparam int EXC_MODES = 4;               // irq, svc, abt, und
    localparam int FIQ_BASE  = USR_COUNT;
    localparam int EXC_BASE  = FIQ_BASE + FIQ_COUNT;
    localparam int NUM_PHYS  = EXC_BASE + 2 * EXC_MODES;
    localparam int PHYS_W    = $clog2(NUM_PHYS);
    localparam int SR_COUNT  = 1 + EXC_MODES;

    // Map a mode code to its bank class; unknown codes and system mode are user.
    function automatic mode_cls_e decode_mode(input logic [4:0] m);
        case (m)
            MODE_FIQ: return CL_FIQ;
            MODE_IRQ: return CL_IRQ;
            MODE_SVC: return CL_SVC;
            MODE_ABT: return CL_ABT;
            MODE_UND: return CL_UND;
            default:  return CL_USR;
        endcase
    endfunction

endpackage

// File: rtl/brf_index_map.sv
// Module: brf_index_map
// Translates one architectural register index plus the current bank class
// into a physical register number. Flags index 15, which is not stored.
// Assumes the physical layout fixed in banked_rf_pkg.
module brf_index_map
    import banked_rf_pkg::*;
(
    input  logic [IDX_W-1:0]  arch_idx,
    input  mode_cls_e         cls,
    output logic [PHYS_W-1:0] phys_idx,
    output logic              is_pc
);

    // Choose the physical slot from index and bank class.
    always_comb begin
        is_pc    = (int'(arch_idx) == PC_IDX);
        phys_idx = is_pc ? '0 : PHYS_W'(arch_idx);
        if (!is_pc) begin
            if (cls == CL_FIQ && int'(arch_idx) >= FIQ_FIRST) begin
                phys_idx = PHYS_W'(FIQ_BASE + int'(arch_idx) - FIQ_FIRST);
            end else if (cls != CL_USR && cls != CL_FIQ && int'(arch_idx) >= 13) begin
                phys_idx = PHYS_W'(EXC_BASE + 2 * (int'(cls) - int'(CL_IRQ))
                                   + int'(arch_idx) - 13);
            end
        end
    end

endmodule

// File: rtl/brf_gpr_store.sv
// Module: brf_gpr_store
// Flat physical register storage: two combinational read ports and one
// clocked write port. No bypass, so a read sees the value from before the edge.
// Assumes indices are below DEPTH.
module brf_gpr_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 30,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [AW-1:0]     rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic              we,
    input  logic [AW-1:0]     w_idx,
    input  logic [DATA_W-1:0] w_data
);

    logic [DATA_W-1:0] regs [DEPTH];

    // One flop row per physical register, cleared on reset.
    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                       regs[g] <= '0;
            else if (we && int'(w_idx) == g) regs[g] <= w_data;
        end
    end

    // Read port multiplexers.
    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

endmodule

// File: rtl/brf_status_bank.sv
// Module: brf_status_bank
// Saved-status words, one per exception bank class. User class has no word:
// it reads zero and discards writes. Assumes the class order in banked_rf_pkg.
module brf_status_bank
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_cls_e         cls,
    input  logic              we,
    input  logic [DATA_W-1:0] w_data,
    output logic [DATA_W-1:0] r_data
);

    localparam int SLOTS = SR_COUNT;

    logic [DATA_W-1:0] words [SLOTS];

    // Each exception class owns one word, written only while it is current.
    for (genvar g = 0; g < SLOTS; g++) begin : g_sr
        always_ff @(posedge clk) begin
            if (!rst_n)                           words[g] <= '0;
            else if (we && int'(cls) == g + 1)    words[g] <= w_data;
        end
    end

    // Current word, or zero when the class has none.
    always_comb begin
        r_data = '0;
        for (int i = 0; i < SLOTS; i++)
            if (int'(cls) == i + 1) r_data = words[i];
    end

endmodule

// File: rtl/banked_regfile.sv
// Module: banked_regfile (top)
// Mode-banked register file: decodes the mode and maps the index of each
// port to a physical register. Index 15 reads return pc_in, and index 15
// writes become a pc_write strobe. Assumes one write per cycle.
module banked_regfile
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] pc_in,
    output logic              pc_write,
    input  logic              sr_wr_en,
    input  logic [DATA_W-1:0] sr_wr_data,
    output logic [DATA_W-1:0] sr_rd_data
);

    localparam int NPORT = 3;   // read A, read B, write

    mode_cls_e          cls;
    logic [IDX_W-1:0]   port_idx  [NPORT];
    logic [PHYS_W-1:0]  port_phys [NPORT];
    logic               port_pc   [NPORT];
    logic [DATA_W-1:0]  store_a, store_b;

    // Bank class of the current mode.
    assign cls = decode_mode(mode);

    // Gather the indices of the three ports for the mappers.
    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        brf_index_map u_map (
            .arch_idx (port_idx[p]),
            .cls      (cls),
            .phys_idx (port_phys[p]),
            .is_pc    (port_pc[p])
        );
    end

    brf_gpr_store #(.DATA_W(DATA_W), .DEPTH(NUM_PHYS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (port_phys[0]),
        .ra_data (store_a),
        .rb_idx  (port_phys[1]),
        .rb_data (store_b),
        .we      (wr_en && !port_pc[2]),
        .w_idx   (port_phys[2]),
        .w_data  (wr_data)
    );

    brf_status_bank #(.DATA_W(DATA_W)) u_sr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cls    (cls),
        .we     (sr_wr_en),
        .w_data (sr_wr_data),
        .r_data (sr_rd_data)
    );

    // Index 15 is served by the external program counter.
    assign rd_a_data = port_pc[0] ? pc_in : store_a;
    assign rd_b_data = port_pc[1] ? pc_in : store_b;
    assign pc_write  = wr_en && port_pc[2];

endmodule

// File: rtl/brf_checker.sv
// Module: brf_checker
// Port-level properties of banked_regfile, bound to every instance.
module brf_checker
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [3:0]        rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] pc_in,
    input logic              pc_write,
    input logic              sr_wr_en,
    input logic [DATA_W-1:0] sr_rd_data
);

    p_pc_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 4'd15) |-> (rd_a_data == pc_in));

    p_pc_read_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 4'd15) |-> (rd_b_data == pc_in));

    p_pc_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_write |-> (wr_en && wr_idx == 4'd15));

    p_write_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != 4'd15) |=>
        (rd_a_idx != $past(wr_idx) || mode != $past(mode) || rd_a_data == $past(wr_data)));

    p_sr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_wr_en |=> (mode != $past(mode) || sr_rd_data == $past(sr_rd_data)));

    p_sr_user_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_mode(mode) == CL_USR) |-> (sr_rd_data == '0));

endmodule

bind banked_regfile brf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_idx   (rd_b_idx),
    .rd_b_data  (rd_b_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .pc_in      (pc_in),
    .pc_write   (pc_write),
    .sr_wr_en   (sr_wr_en),
    .sr_rd_data (sr_rd_data)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = 5'b10000;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, sr_rd_data;
    logic        wr_en = 1'b0, sr_wr_en = 1'b0, pc_write;
    logic [31:0] wr_data = '0, pc_in = '0, sr_wr_data = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    banked_regfile #(.DATA_W(32)) u_dut (.*);

    // Reference state, kept per owner rather than per physical slot.
    logic [31:0] m_usr  [15];
    logic [31:0] m_fiq  [7];
    logic [31:0] m_exc  [4][2];
    logic [31:0] m_sr   [5];

    // Owner class from the mode codes in R4/R5: 0 user, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und.
    function automatic int owner(input logic [4:0] m);
        if (m == 5'b10001) return 1;
        if (m == 5'b10010) return 2;
        if (m == 5'b10011) return 3;
        if (m == 5'b10111) return 4;
        if (m == 5'b11011) return 5;
        return 0;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [4:0] m, input logic [3:0] i);
        int o = owner(m);
        if (i == 4'd15) return pc_in;
        if (o == 1 && i >= 4'd8) return m_fiq[i - 8];
        if (o >= 2 && i >= 4'd13) return m_exc[o - 2][i - 13];
        return m_usr[i];
    endfunction

    function automatic logic [31:0] exp_sr(input logic [4:0] m);
        int o = owner(m);
        return (o == 0) ? 32'd0 : m_sr[o - 1];
    endfunction

    function automatic string tag(input logic [3:0] i);
        if (i == 4'd15) return "R6";
        if (i < 4'd8)   return "R2";
        if (i < 4'd13)  return "R3";
        return "R4";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, commit at posedge.
    task automatic step(input logic [4:0] m, input logic [3:0] ra, input logic [3:0] rb,
                        input logic we, input logic [3:0] wi, input logic [31:0] wd,
                        input logic swe, input logic [31:0] swd, input logic [31:0] pc);
        int o;
        @(negedge clk);
        mode = m; rd_a_idx = ra; rd_b_idx = rb; wr_en = we; wr_idx = wi;
        wr_data = wd; sr_wr_en = swe; sr_wr_data = swd; pc_in = pc;
        #1;
        chk((we && wi == ra) ? {tag(ra), " R8"} : tag(ra), rd_a_data, exp_rd(m, ra));
        chk({tag(rb), " R11"}, rd_b_data, exp_rd(m, rb));
        chk(owner(m) == 0 ? "R10" : "R9", sr_rd_data, exp_sr(m));
        chk("R7", {31'd0, pc_write}, {31'd0, we && wi == 4'd15});
        @(posedge clk);
        o = owner(m);
        if (we && wi != 4'd15) begin
            if (o == 1 && wi >= 4'd8)       m_fiq[wi - 8] = wd;
            else if (o >= 2 && wi >= 4'd13) m_exc[o - 2][wi - 13] = wd;
            else                            m_usr[wi] = wd;
        end
        if (swe && o != 0) m_sr[o - 1] = swd;
    endtask

    localparam logic [4:0] MODES [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                         5'b10111, 5'b11011, 5'b11111};

    initial begin
        #(5 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 15; i++) m_usr[i] = '0;
        for (int i = 0; i < 7; i++)  m_fiq[i] = '0;
        for (int i = 0; i < 4; i++) begin m_exc[i][0] = '0; m_exc[i][1] = '0; end
        for (int i = 0; i < 5; i++)  m_sr[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: everything reads zero after reset in every mode.
        for (int k = 0; k < 7; k++)
            for (int i = 0; i < 15; i++) begin
                step(MODES[k], 4'(i), 4'(14 - i), 1'b0, 4'd0, '0, 1'b0, '0, 32'h100);
                chk("R1", rd_a_data, 32'd0);
            end

        // R3/R4: fill user r7..r14, then fast-interrupt r7..r14 must show user r7 only.
        for (int i = 7; i < 15; i++)
            step(5'b10000, 4'd0, 4'd0, 1'b1, 4'(i), 32'hA000 + i, 1'b0, '0, 32'h0);
        step(5'b10001, 4'd7, 4'd8, 1'b0, 4'd0, '0, 1'b0, '0, 32'h0);
        chk("R2", rd_a_data, 32'hA007);
        chk("R3", rd_b_data, 32'd0);
        step(5'b10001, 4'd12, 4'd13, 1'b1, 4'd12, 32'hF12, 1'b0, '0, 32'h0);
        chk("R3", rd_b_data, 32'd0);
        step(5'b10000, 4'd12, 4'd13, 1'b0, 4'd0, '0, 1'b0, '0, 32'h0);
        chk("R3", rd_a_data, 32'hA00C);
        chk("R4", rd_b_data, 32'hA00D);
        // R4: system and user share r13; undefined mode has its own.
        step(5'b11111, 4'd13, 4'd14, 1'b1, 4'd13, 32'h5157, 1'b0, '0, 32'h0);
        step(5'b11011, 4'd13, 4'd14, 1'b0, 4'd0, '0, 1'b0, '0, 32'h0);
        chk("R4", rd_a_data, 32'd0);
        step(5'b10000, 4'd13, 4'd13, 1'b0, 4'd0, '0, 1'b0, '0, 32'h0);
        chk("R4", rd_a_data, 32'h5157);
        // R5: unknown code 00101 writes the user r14.
        step(5'b00101, 4'd14, 4'd0, 1'b1, 4'd14, 32'hBAD5, 1'b1, 32'h77, 32'h0);
        step(5'b10000, 4'd14, 4'd0, 1'b0, 4'd0, '0, 1'b0, '0, 32'h0);
        chk("R5", rd_a_data, 32'hBAD5);
        chk("R5", sr_rd_data, 32'd0);
        // R6/R7: index 15 reads pc_in and a write to it touches nothing.
        step(5'b10001, 4'd15, 4'd15, 1'b1, 4'd15, 32'hDEAD, 1'b0, '0, 32'h1234);
        chk("R6", rd_a_data, 32'h1234);
        chk("R7", {31'd0, pc_write}, 32'd1);
        step(5'b10000, 4'd0, 4'd8, 1'b0, 4'd0, '0, 1'b0, '0, 32'h0);
        chk("R7", rd_a_data, 32'd0);
        // R8: same-cycle read sees the old value, next cycle the new one.
        step(5'b10010, 4'd3, 4'd3, 1'b1, 4'd3, 32'h3333, 1'b0, '0, 32'h0);
        chk("R8", rd_a_data, 32'd0);
        step(5'b10010, 4'd3, 4'd3, 1'b0, 4'd0, '0, 1'b0, '0, 32'h0);
        chk("R8", rd_a_data, 32'h3333);
        // R9/R10: distinct saved status per exception mode; user/system discard.
        for (int k = 1; k < 6; k++)
            step(MODES[k], 4'd0, 4'd0, 1'b0, 4'd0, '0, 1'b1, 32'h50 + k, 32'h0);
        step(5'b11111, 4'd0, 4'd0, 1'b0, 4'd0, '0, 1'b1, 32'hFFFF, 32'h0);
        chk("R10", sr_rd_data, 32'd0);
        for (int k = 1; k < 6; k++) begin
            step(MODES[k], 4'd0, 4'd0, 1'b0, 4'd0, '0, 1'b0, '0, 32'h0);
            chk("R9", sr_rd_data, 32'h50 + k);
        end

        // Random phase against the reference state.
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] m;
            m = ($urandom % 8 == 0) ? 5'($urandom) : MODES[$urandom % 7];
            step(m, 4'($urandom), 4'($urandom), 1'($urandom), 4'($urandom), $urandom,
                 ($urandom % 4 == 0), $urandom, $urandom);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule